// File: doc/BRIEF.md
# Range-Programmable Synchronous Counter

This block is a synchronous binary counter built from 4-bit slices, chained through their terminal carries so that a wider counter forms. With the default two slices it counts through 256 states. Each slice has two count enables: the shared `en_p` gates only the state update, while `en_t` gates both the update and the carry. Each slice also has a synchronous clear, a synchronous parallel load and a direction select. The carry output is active low. It goes low at the last state of the current direction: all ones when counting up, all zeros when counting down.

A range controller wraps the slices. When range mode is on and the count reaches a chosen end value, the controller pulls the internal load low through combinational logic. On that same clock edge a chosen start value is loaded in place of the next count step. No state outside the range ever appears. The block then cycles through |end − start| + 1 states, either upward or downward.

In free-running use, with range mode off and both enables high, state bit k serves as a divide-by-2^(k+1) clock divider.

Top module: `rngcnt_top`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes 0 on that edge, whatever the load, enable and range inputs are.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `q` takes `ld_data` on that edge, whatever the enables and range mode are.
- R3: With `clr_n` and `ld_n` high, `q` holds its value unless `en_p` and `en_t` are both high.
- R4: When counting is enabled, `up`=1 and range mode is off or not at its end value, `q` increments by one per edge and wraps from 0xFF to 0x00.
- R5: When counting is enabled with `up`=0 under the same conditions as R4, `q` decrements by one per edge and wraps from 0x00 to 0xFF.
- R6: `rco_n` is low exactly when `en_t` is high and `q` is 0xFF with `up`=1, or `q` is 0x00 with `up`=0. It does not depend on `en_p`.
- R7: With `range_en`=1 and counting enabled, a `q` equal to `end_val` is replaced by `start_val` on the next edge. The counter then repeats a cycle of |end − start| + 1 states. Examples: 5→15, 3→12, 0→10 counting up, and 8→0 counting down.
- R8: An upper 4-bit slice changes on a counting edge only when every slice below it sits at its terminal value for the current direction.
- R9: When free-running upward from 0 for 256 edges, bit k of `q` toggles exactly 256/2^k times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable for state changes only |
| en_t | input | 1 | Count enable for state changes and carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| range_en | input | 1 | Enables end-detect and start-reload |
| end_val | input | 8 | Detected end state in range mode |
| start_val | input | 8 | State loaded after the end state |
| ld_data | input | 8 | Parallel load data |
| q | output | 8 | Counter state |
| rco_n | output | 1 | Ripple carry, active low, from the top slice |

## Verification
`q` is registered, so every control input takes effect on the rising edge that samples it and shows up one edge later. `rco_n` is combinational from `q`, `en_t` and `up`, so it is due in the same cycle as those inputs. The bench drives inputs just after a falling edge and checks `rco_n` 1 ns later, before any clock edge. It then lets exactly one rising edge pass and compares `q` at the next falling edge against a reference model that was also stepped once. The range configurations are each run for more than two full periods, so every reload is checked where it lands.

// File: rtl/rngcnt_pkg.sv
package rngcnt_pkg;
  localparam int SLICE_W = 4;

  // True when a slice value is the last state for the given direction.
  function automatic logic at_terminal(input logic [SLICE_W-1:0] v, input logic dir_up);
    return dir_up ? (&v) : ~(|v);
  endfunction
endpackage

// File: rtl/rngcnt_slice.sv
module rngcnt_slice
  import rngcnt_pkg::*;
(
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic               up,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               rco_n
);
  always_ff @(posedge clk) begin
    if (!clr_n)             q <= '0;
    else if (!ld_n)         q <= d;
    else if (en_p && en_t)  q <= up ? q + 1'b1 : q - 1'b1;
  end

  assign rco_n = ~(en_t & at_terminal(q, up));

  assert_clear_R1: assert property (@(posedge clk) !clr_n |=> (q == '0));
  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (q == $past(d)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/rngcnt_range_ctrl.sv
module rngcnt_range_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic         range_en,
  input  logic [W-1:0] end_val,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] q,
  output logic         ld_eff_n,
  output logic [W-1:0] load_val
);
  logic hit;

  // End detect drives the load combinationally: reload replaces the step.
  assign hit      = range_en & en_p & en_t & (q == end_val);
  assign ld_eff_n = ld_n & ~hit;
  assign load_val = ld_n ? start_val : ld_data;

  assert_reload_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && range_en && en_p && en_t && q == end_val) |=> (q == $past(start_val)));
endmodule

// File: rtl/rngcnt_top.sv
module rngcnt_top
  import rngcnt_pkg::*;
#(
  parameter int NSLICE = 2,
  localparam int W = NSLICE * SLICE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic         up,
  input  logic         range_en,
  input  logic [W-1:0] end_val,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] q,
  output logic         rco_n
);
  logic              ld_eff_n;
  logic [W-1:0]      load_val;
  logic [NSLICE:0]   t_chain;
  logic [NSLICE-1:0] rco_s;

  assign t_chain[0] = en_t;

  rngcnt_range_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .range_en(range_en), .end_val(end_val), .start_val(start_val),
    .ld_data(ld_data), .q(q), .ld_eff_n(ld_eff_n), .load_val(load_val)
  );

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    rngcnt_slice u_slice (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_eff_n), .en_p(en_p),
      .en_t(t_chain[i]), .up(up),
      .d(load_val[i*SLICE_W +: SLICE_W]),
      .q(q[i*SLICE_W +: SLICE_W]),
      .rco_n(rco_s[i])
    );
    assign t_chain[i+1] = ~rco_s[i];

    if (i > 0) begin : g_casc_chk
      assert_cascade_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_eff_n && rco_s[i-1]) |=> $stable(q[i*SLICE_W +: SLICE_W]));
    end
  end

  assign rco_n = rco_s[NSLICE-1];
endmodule

// File: tb/rngcnt_top_test.sv
module rngcnt_top_test;
  logic       clk = 1'b0;
  logic       clr_n, ld_n, en_p, en_t, up, range_en;
  logic [7:0] end_val, start_val, ld_data, q;
  logic       rco_n;
  logic [7:0] m;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rngcnt_top uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t), .up(up),
    .range_en(range_en), .end_val(end_val), .start_val(start_val),
    .ld_data(ld_data), .q(q), .rco_n(rco_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic c, l, p, t, u, r, input logic [7:0] e);
    if (!c) return "R1";
    if (!l) return "R2";
    if (!(p && t)) return "R3";
    if (r && m == e) return "R7";
    if (u ? (m[3:0] == 4'hF) : (m[3:0] == 4'h0)) return "R8";
    return u ? "R4" : "R5";
  endfunction

  function automatic logic [7:0] model_next(input logic c, l, p, t, u, r,
                                            input logic [7:0] ld, e, s);
    if (!c) return 8'h00;
    if (!l) return ld;
    if (!(p && t)) return m;
    if (r && m == e) return s;
    return u ? m + 8'd1 : m - 8'd1;
  endfunction

  task automatic step(input logic c, l, p, t, u, r, input logic [7:0] ld, e, s);
    string tg;
    clr_n = c; ld_n = l; en_p = p; en_t = t; up = u; range_en = r;
    ld_data = ld; end_val = e; start_val = s;
    #1;
    check("R6 rco_n", {31'd0, rco_n}, {31'd0, ~(t && (u ? m == 8'hFF : m == 8'h00))});
    tg = tag_of(c, l, p, t, u, r, e);
    @(posedge clk);
    m = model_next(c, l, p, t, u, r, ld, e, s);
    @(negedge clk);
    check(tg, {24'd0, q}, {24'd0, m});
  endtask

  task automatic run_range(input logic u, input logic [7:0] e, input logic [7:0] s);
    int modn = (u ? int'(e) - int'(s) : int'(s) - int'(e)) + 1;
    step(1, 0, 1, 1, u, 1, s, e, s);
    for (int k = 0; k < 2 * modn + 2; k++) step(1, 1, 1, 1, u, 1, 8'h00, e, s);
  endtask

  initial begin
    int tog [8];
    logic [7:0] prev;
    void'($urandom(32'd2024));
    m = 8'h00;
    @(negedge clk);
    // R1: clear wins over load and counting
    step(0, 0, 1, 1, 1, 1, 8'hA5, 8'h00, 8'h00);
    check("R1 reset", {24'd0, q}, 32'd0);
    // R2: load with enables low
    step(1, 0, 0, 0, 1, 0, 8'h3C, 8'h00, 8'h00);
    // R3: each enable alone holds; R6 carry with en_p low
    step(1, 1, 0, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    step(1, 1, 1, 0, 1, 0, 8'h00, 8'h00, 8'h00);
    step(1, 0, 0, 1, 1, 0, 8'hFF, 8'h00, 8'h00);
    step(1, 1, 0, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    // R4 wrap up through 0xFF, R8 nibble carry
    step(1, 0, 1, 1, 1, 0, 8'hFD, 8'h00, 8'h00);
    for (int k = 0; k < 4; k++) step(1, 1, 1, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    // R5 wrap down through 0x00
    step(1, 0, 1, 1, 0, 0, 8'h02, 8'h00, 8'h00);
    for (int k = 0; k < 4; k++) step(1, 1, 1, 1, 0, 0, 8'h00, 8'h00, 8'h00);
    // R7 ranges
    run_range(1, 8'h0F, 8'h05);
    run_range(1, 8'h0C, 8'h03);
    run_range(0, 8'h00, 8'h08);
    run_range(1, 8'h0A, 8'h00);
    run_range(1, 8'hC3, 8'h40);
    // R9 free-running divider
    step(0, 1, 1, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    for (int b = 0; b < 8; b++) tog[b] = 0;
    prev = q;
    for (int k = 0; k < 256; k++) begin
      step(1, 1, 1, 1, 1, 0, 8'h00, 8'h00, 8'h00);
      for (int b = 0; b < 8; b++) if (q[b] != prev[b]) tog[b]++;
      prev = q;
    end
    for (int b = 0; b < 8; b++) check("R9 toggles", tog[b], 256 >> b);
    // Random mix against the model
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 20) != 0, ($urandom % 10) != 0, ($urandom % 6) != 0,
           ($urandom % 6) != 0, 1'($urandom), 1'($urandom),
           8'($urandom), 8'($urandom % 24), 8'($urandom % 24));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule